// File: doc/BRIEF.md
# Configurable Logic Macrocell

This block is one programmable logic cell. It takes five product-term inputs, a cascade sum from the neighbouring cell, three global clocks, a global clear and a pin input. It ORs a chosen set of product terms into a sum term and passes that sum through an XOR stage that sets the polarity. The result goes into one storage element. That element can act as a D, T, JK or SR flip-flop, or as a transparent latch. The cell drives a visible output and a separate buried feedback. Each of the two can be taken from the register or from the combinational path, and the two choices are independent. The sum term also leaves the cell as a cascade output, so that cells can be chained into wide sums.

The whole model runs on one system clock `clk`. The global clocks and the product-term clock are sampled signals. A cell clock "edge" is a low-to-high change of the selected clock seen between two system-clock samples, and the register updates on that same system edge. Clear and preset are level inputs that override all clocking and take effect on the next system edge. The configuration word is captured only while `cfg_ld` is high.

Fixed product-term roles: pt[0] is the XOR operand and the K/R input, pt[1] is the clock or clock enable, pt[2] is the reset term, pt[3] is the preset term, and pt[4] is the dedicated data term.

Configuration word bits: [20:16] sum mask; [15] cascade enable; [14:13] XOR operand (0 zero, 1 one, 2 pt[0], 3 register state); [12:11] data source (0 XOR output, 1 pt[4], 2 pin, 3 XOR output); [10:8] mode (0 D, 1 T, 2 JK, 3 SR, 4 latch, 5 to 7 act as D); [7:6] clock (0 to 2 gclk[n], 3 pt[1]); [5] clock-enable on; [4:3] reset source (0 off, 1 gclr, 2 pt[2], 3 gclr or pt[2]); [2] preset on; [1] output registered; [0] feedback registered.

Top module: `plm_cell`

## Requirements
- R1: `cas_out` equals the OR of every pt[i] whose mask bit [16+i] is 1, ORed with `cas_in` when bit [15] is 1.
- R2: The XOR output is the sum term XOR the operand that field [14:13] selects. Operand 1 inverts the sum, and operand 3 uses the register state.
- R3: The register data input comes from the XOR output, pt[4] or `pin`, as field [12:11] selects.
- R4: In D mode the register loads the data input on each rising edge of the clock that field [7:6] selects. At any other time it holds.
- R5: With a global clock selected and bit [5] set, a rising edge is ignored while pt[1] is low.
- R6: In T mode a clock edge toggles the state when the data input is 1. In JK mode the next state is (J and not Q) or (not K and Q), with J the data input and K pt[0].
- R7: In SR mode S is the data input and R is pt[0]. S alone sets, R alone clears, and both set or both clear hold the state.
- R8: In latch mode the register follows the data input while the selected clock (gated by the enable of R5) is high, and holds while it is low.
- R9: The reset selected by field [4:3] clears the register on the next system edge, whatever the clock. Reset wins over preset.
- R10: With bit [2] set, pt[3] high sets the register on the next system edge when no reset is active.
- R11: `cell_out` shows the register when bit [1] is 1 and the XOR output otherwise. `fb_out` does the same from bit [0], independently of `cell_out`.
- R12: The configuration changes only on a system edge where `cfg_ld` is high. A new `cfg_word` has no effect while `cfg_ld` is low.
- R13: After reset the configuration is all zeros and the register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_ld | input | 1 | Configuration capture strobe |
| cfg_word | input | 21 | Configuration word |
| pt | input | 5 | Product-term inputs |
| cas_in | input | 1 | Cascade sum from the neighbouring cell |
| gclk | input | 3 | Global clocks (sampled) |
| gclr | input | 1 | Global clear |
| pin | input | 1 | Pin input |
| cell_out | output | 1 | Visible output |
| fb_out | output | 1 | Buried feedback |
| cas_out | output | 1 | Cascade sum to the next cell |

## Verification
On every cycle the assertions check four things: clear beats preset, preset sets the register, the register holds when no edge and no override is present, and the latch and SR hold cases. They also check that the configuration holds while the strobe is low. Only the bench scenarios can show that the sum term, the polarity, the data source, the clock selection with enable, and the T, JK and SR next-state equations give the right values. The bench does this by sweeping modes, sources and clocks under pseudo-random input streams against an arithmetic model.

// File: rtl/plm_pkg.sv
package plm_pkg;
    localparam int NPT   = 5;
    localparam int NGCLK = 3;
    localparam int CSW   = $clog2(NGCLK + 1);

    localparam int PT_XOR = 0;
    localparam int PT_CLK = 1;
    localparam int PT_AR  = 2;
    localparam int PT_AP  = 3;
    localparam int PT_DAT = 4;

    typedef enum logic [2:0] {
        MD_D = 3'd0, MD_T = 3'd1, MD_JK = 3'd2, MD_SR = 3'd3, MD_LAT = 3'd4,
        MD_R5 = 3'd5, MD_R6 = 3'd6, MD_R7 = 3'd7
    } mode_e;

    typedef enum logic [1:0] {XS_ZERO, XS_ONE, XS_PT, XS_STATE} xsel_e;
    typedef enum logic [1:0] {DS_XOR, DS_PT, DS_PIN, DS_XOR2} dsrc_e;
    typedef enum logic [1:0] {AR_OFF, AR_GCLR, AR_PT, AR_BOTH} arsel_e;

    typedef struct packed {
        logic [NPT-1:0] sum_en;
        logic           cas_en;
        xsel_e          xsel;
        dsrc_e          dsrc;
        mode_e          mode;
        logic [CSW-1:0] clk_sel;
        logic           ce_en;
        arsel_e         ar_sel;
        logic           ap_en;
        logic           out_reg;
        logic           fb_reg;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/plm_sum.sv
module plm_sum
    import plm_pkg::*;
(
    input  logic [NPT-1:0] pt,
    input  logic [NPT-1:0] sum_en,
    input  logic           cas_en,
    input  logic           cas_in,
    input  xsel_e          xsel,
    input  logic           state,
    output logic           sum,
    output logic           xo
);
    logic operand;

    always_comb begin
        sum = (|(pt & sum_en)) | (cas_en & cas_in);
        case (xsel)
            XS_ZERO:  operand = 1'b0;
            XS_ONE:   operand = 1'b1;
            XS_PT:    operand = pt[PT_XOR];
            default:  operand = state;
        endcase
        xo = sum ^ operand;
    end
endmodule

// File: rtl/plm_clkctl.sv
module plm_clkctl
    import plm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NGCLK-1:0] gclk,
    input  logic             pt_clk,
    input  logic [CSW-1:0]   clk_sel,
    input  logic             ce_en,
    input  logic             gclr,
    input  logic             pt_ar,
    input  arsel_e           ar_sel,
    input  logic             pt_ap,
    input  logic             ap_en,
    output logic             fire,
    output logic             open,
    output logic             ar_act,
    output logic             ap_act
);
    localparam int NSRC = NGCLK + 1;

    typedef struct packed {
        logic [NSRC-1:0] prev;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [NSRC-1:0] srcs;
    logic            cur, was, use_glb, en;

    always_comb begin
        srcs    = {pt_clk, gclk};
        cur     = srcs[clk_sel];
        was     = ctl_q.prev[clk_sel];
        use_glb = clk_sel < CSW'(NGCLK);
        en      = (use_glb && ce_en) ? pt_clk : 1'b1;
        fire    = cur & ~was & en;
        open    = cur & en;
        case (ar_sel)
            AR_GCLR: ar_act = gclr;
            AR_PT:   ar_act = pt_ar;
            AR_BOTH: ar_act = gclr | pt_ar;
            default: ar_act = 1'b0;
        endcase
        ap_act     = ap_en & pt_ap;
        ctl_d.prev = srcs;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // R5
    gated_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (use_glb && ce_en && !pt_clk) |-> (!fire && !open));
endmodule

// File: rtl/plm_store.sv
module plm_store
    import plm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e mode,
    input  logic  din,
    input  logic  kr,
    input  logic  fire,
    input  logic  open,
    input  logic  ar_act,
    input  logic  ap_act,
    output logic  q
);
    typedef struct packed {
        logic q;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ar_act) begin
            st_d.q = 1'b0;
        end else if (ap_act) begin
            st_d.q = 1'b1;
        end else if (mode == MD_LAT) begin
            if (open) st_d.q = din;
        end else if (fire) begin
            case (mode)
                MD_T:    st_d.q = st_q.q ^ din;
                MD_JK:   st_d.q = (din & ~st_q.q) | (~kr & st_q.q);
                MD_SR:   st_d.q = (din ^ kr) ? din : st_q.q;
                default: st_d.q = din;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.q;

    // R9
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ar_act |=> !q);
    // R10
    preset_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_act && !ar_act) |=> q);
    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ar_act && !ap_act && !fire && mode != MD_LAT) |=> $stable(q));
    // R7
    sr_both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_SR && din && kr && !ar_act && !ap_act) |=> $stable(q));
    // R8
    latch_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_LAT && !open && !ar_act && !ap_act) |=> $stable(q));
endmodule

// File: rtl/plm_cell.sv
module plm_cell
    import plm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_ld,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic [NPT-1:0]   pt,
    input  logic             cas_in,
    input  logic [NGCLK-1:0] gclk,
    input  logic             gclr,
    input  logic             pin,
    output logic             cell_out,
    output logic             fb_out,
    output logic             cas_out
);
    cfg_t cfg_d, cfg_q;
    logic sum, xo, q, din, fire, open, ar_act, ap_act;

    always_comb begin
        cfg_d = cfg_ld ? cfg_t'(cfg_word) : cfg_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    plm_sum u_sum (
        .pt(pt), .sum_en(cfg_q.sum_en), .cas_en(cfg_q.cas_en), .cas_in(cas_in),
        .xsel(cfg_q.xsel), .state(q), .sum(sum), .xo(xo)
    );

    plm_clkctl u_ctl (
        .clk(clk), .rst_n(rst_n), .gclk(gclk), .pt_clk(pt[PT_CLK]),
        .clk_sel(cfg_q.clk_sel), .ce_en(cfg_q.ce_en), .gclr(gclr),
        .pt_ar(pt[PT_AR]), .ar_sel(cfg_q.ar_sel), .pt_ap(pt[PT_AP]),
        .ap_en(cfg_q.ap_en), .fire(fire), .open(open),
        .ar_act(ar_act), .ap_act(ap_act)
    );

    always_comb begin
        case (cfg_q.dsrc)
            DS_PT:   din = pt[PT_DAT];
            DS_PIN:  din = pin;
            default: din = xo;
        endcase
    end

    plm_store u_st (
        .clk(clk), .rst_n(rst_n), .mode(cfg_q.mode), .din(din), .kr(pt[PT_XOR]),
        .fire(fire), .open(open), .ar_act(ar_act), .ap_act(ap_act), .q(q)
    );

    assign cell_out = cfg_q.out_reg ? q : xo;
    assign fb_out   = cfg_q.fb_reg  ? q : xo;
    assign cas_out  = sum;

    // R12
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ld |=> $stable(cfg_q));
endmodule

// File: tb/test_plm_cell.sv
module test_plm_cell;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_ld = 1'b0;
    logic [20:0] cfg_word = '0;
    logic [4:0]  pt = '0;
    logic        cas_in = 1'b0;
    logic [2:0]  gclk = '0;
    logic        gclr = 1'b0;
    logic        pin = 1'b0;
    logic        cell_out, fb_out, cas_out;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    bit [20:0] m_cfg = '0;
    bit        m_q = 0;
    bit [3:0]  m_prev = '0;
    bit [31:0] rs = 32'h1234_5678;

    always #5ns clk = ~clk;

    plm_cell i_plm_cell (
        .clk(clk), .rst_n(rst_n), .cfg_ld(cfg_ld), .cfg_word(cfg_word), .pt(pt),
        .cas_in(cas_in), .gclk(gclk), .gclr(gclr), .pin(pin),
        .cell_out(cell_out), .fb_out(fb_out), .cas_out(cas_out)
    );

    function automatic bit [20:0] mk(bit [4:0] se, bit ce_cas, bit [1:0] xs, bit [1:0] ds,
                                     bit [2:0] md, bit [1:0] cs, bit ce, bit [1:0] ar,
                                     bit ap, bit outr, bit fbr);
        return {se, ce_cas, xs, ds, md, cs, ce, ar, ap, outr, fbr};
    endfunction

    function automatic bit [31:0] nxt_rand(bit [31:0] s);
        bit [31:0] v = s;
        v ^= v << 13; v ^= v >> 17; v ^= v << 5;
        return v;
    endfunction

    function automatic bit m_sum(bit [20:0] w, bit [4:0] p, bit c);
        return (|(p & w[20:16])) | (w[15] & c);
    endfunction

    function automatic bit m_xor(bit [20:0] w, bit [4:0] p, bit c, bit q);
        bit op;
        case (w[14:13])
            2'd0: op = 0;
            2'd1: op = 1;
            2'd2: op = p[0];
            default: op = q;
        endcase
        return m_sum(w, p, c) ^ op;
    endfunction

    task automatic chk(bit act, bit exp, string req);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic tick(bit ld, bit [20:0] wd, bit [4:0] p, bit c, bit [2:0] g,
                        bit gc, bit pn, string tag);
        bit x, d, sel, was, en, fire, opn, ar, ap, nq;
        bit [3:0] srcs;
        bit [2:0] md;
        @(negedge clk);
        cfg_ld = ld; cfg_word = wd; pt = p; cas_in = c; gclk = g; gclr = gc; pin = pn;
        x = m_xor(m_cfg, p, c, m_q);
        case (m_cfg[12:11])
            2'd1: d = p[4];
            2'd2: d = pn;
            default: d = x;
        endcase
        srcs = {p[1], g};
        sel  = srcs[m_cfg[7:6]];
        was  = m_prev[m_cfg[7:6]];
        en   = (m_cfg[7:6] != 2'd3 && m_cfg[5]) ? p[1] : 1'b1;
        fire = sel & ~was & en;
        opn  = sel & en;
        case (m_cfg[4:3])
            2'd1: ar = gc;
            2'd2: ar = p[2];
            2'd3: ar = gc | p[2];
            default: ar = 0;
        endcase
        ap = m_cfg[2] & p[3];
        md = m_cfg[10:8];
        nq = m_q;
        if (ar) nq = 0;
        else if (ap) nq = 1;
        else if (md == 3'd4) begin
            if (opn) nq = d;
        end else if (fire) begin
            case (md)
                3'd1: nq = m_q ^ d;
                3'd2: nq = (d & ~m_q) | (~p[0] & m_q);
                3'd3: nq = (d & ~p[0]) ? 1'b1 : ((~d & p[0]) ? 1'b0 : m_q);
                default: nq = d;
            endcase
        end
        @(posedge clk);
        #1;
        m_q = nq;
        m_prev = srcs;
        if (ld) m_cfg = wd;
        x = m_xor(m_cfg, p, c, m_q);
        chk(cell_out, m_cfg[1] ? m_q : x, tag);
        chk(fb_out, m_cfg[0] ? m_q : x, "R11");
        chk(cas_out, m_sum(m_cfg, p, c), "R1");
    endtask

    initial begin
        #(1_500_000ns);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R13: zero config, then registered output shows cleared register
        tick(0, '0, '0, 0, '0, 0, 0, "R13");
        tick(1, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1), '0, 0, '0, 0, 0, "R13");

        // R1, R2: sum and polarity sweep
        for (int xs = 0; xs < 3; xs++) begin
            for (int m = 0; m < 32; m++) begin
                tick(1, mk(5'(m), 1, 2'(xs), 0, 0, 0, 0, 0, 0, 0, 0), '0, 0, '0, 0, 0, "R2");
                for (int v = 0; v < 64; v++) begin
                    tick(0, '0, 5'(v), v[5], '0, 0, 0, "R2");
                end
            end
        end

        // R3: data source from pin and from pt[4]
        tick(1, mk(0, 0, 0, 2, 0, 0, 0, 0, 0, 1, 0), '0, 0, '0, 0, 1, "R3");
        tick(0, '0, '0, 0, 3'b001, 0, 1, "R3");
        tick(0, '0, '0, 0, 3'b000, 0, 0, "R3");
        tick(1, mk(0, 0, 0, 1, 0, 2, 0, 0, 0, 1, 0), '0, 0, '0, 0, 1, "R3");
        tick(0, '0, 5'b00000, 0, 3'b100, 0, 1, "R3");

        // R12: word ignored without strobe
        tick(1, mk(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0), '0, 0, '0, 0, 0, "R12");
        tick(0, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), '0, 0, '0, 0, 0, "R12");
        tick(0, mk(5'h1f, 0, 2, 0, 0, 0, 0, 0, 0, 1, 1), '0, 0, '0, 0, 0, "R12");

        // R9: clear beats preset
        tick(1, mk(0, 0, 1, 0, 0, 0, 0, 2, 1, 1, 1), 5'b01000, 0, '0, 0, 0, "R10");
        tick(0, '0, 5'b01100, 0, '0, 0, 0, "R9");

        // Mode / source / clock sweep under pseudo-random stimulus
        begin
            int idx = 0;
            for (int md = 0; md < 5; md++)
            for (int ds = 0; ds < 3; ds++)
            for (int xs = 0; xs < 4; xs++)
            for (int cs = 0; cs < 4; cs++)
            for (int ce = 0; ce < 2; ce++) begin
                bit [20:0] w;
                w = mk(5'b10101 ^ 5'(idx), 1'(idx >> 5), 2'(xs), 2'(ds), 3'(md), 2'(cs),
                       1'(ce), 2'(idx % 4), 1'((idx / 4) % 2), 1'((idx / 8) % 2),
                       1'((idx / 16) % 2));
                tick(1, w, '0, 0, '0, 0, 0, "R12");
                for (int k = 0; k < 24; k++) begin
                    bit [4:0] p;
                    string tg;
                    rs = nxt_rand(rs);
                    p = {rs[4], &rs[10:8], &rs[7:5], rs[1:0]};
                    if (md == 0)      tg = "R4";
                    else if (md <= 2) tg = "R6";
                    else if (md == 3) tg = "R7";
                    else              tg = "R8";
                    if (cs < 3 && ce == 1) tg = "R5";
                    tick(0, '0, p, rs[18], rs[16:14], &rs[13:11], rs[17], tg);
                end
                idx++;
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule